// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Sequencer

This block is the read side of a burst-capable memory. A single 16-bit configuration word selects between plain asynchronous reads and synchronous burst reads. In burst mode a one-cycle address strobe latches a start address. The block then waits an initial latency and presents successive words from its internal word array at a fixed inter-word spacing. The words follow a sequential or an interleaved order inside a 4- or 8-word window, or run on without end. A ready flag marks when the data on the bus is valid. A bit of the configuration word decides whether that flag moves in step with the data or one cycle ahead of it.

The configuration word is written through a one-cycle write port. It can be read back combinationally at register address 05h. The sequencer is a four-state machine:
- ST_ASYNC: asynchronous mode.
- ST_IDLE: burst mode with no burst running.
- ST_WAIT: counting the initial latency.
- ST_DATA: a word is on the bus.

Its transitions are:
- mode-async: any state to ST_ASYNC when the mode bit reads 1.
- mode-sync: ST_ASYNC to ST_IDLE.
- strobe-latch: any burst-mode state to ST_WAIT.
- latency-expire: ST_WAIT to ST_DATA.
- word-advance: ST_DATA to ST_DATA.
- burst-end: ST_DATA to ST_IDLE after the last word of a finite burst.

The word array holds computed contents. The word at address a is ((a × 2F1Bh) mod 2^16) XOR C3A5h.

Top module: `bsr_burst_reader`

## Requirements
- R1: After reset the configuration word reads 8000h at register address 05h, so the block is in asynchronous mode.
- R2: While bit 15 is 1, rd_ready is 1 and rd_data equals the word at rd_addr in the same cycle. In this mode rd_strobe has no effect.
- R3: sig_data returns the configuration word when sig_addr is 05h and 0000h for any other address. A write presented with cfg_we is visible from the next rising clock edge.
- R4: Take the edge that samples rd_strobe=1 in burst mode as edge 0. The first word of the burst is on rd_data after edge X. X is (bits 13:11 + 2), doubled when bit 10 is 1.
- R5: Each word stays on rd_data for Y cycles. Y is 1 when bit 9 is 0 and 2 when bit 9 is 1, and is doubled when bit 10 is 1.
- R6: When bit 8 is 0, rd_ready is 1 exactly in the cycles where a burst word is on rd_data. When bit 8 is 1, rd_ready in each cycle equals the validity of the following cycle.
- R7: Bits 2:0 set the burst length: 001 gives 4 words, 010 gives 8 words, 111 gives a continuous burst, and any other code gives 4 words. For a finite burst of length L, let o be the start address mod L and let k be the word index. Bit 7 at 1 gives addresses (o+k) mod L within the window. Bit 7 at 0 gives o XOR k within the window. A continuous burst reads start+k, wrapping at the end of the array.
- R8: Bits 14 and 5:3 always read 0, whatever is written to them. Bit 6 is stored and read back, and it has no effect on burst timing or data.
- R9: A strobe that arrives during a burst abandons that burst. The new burst starts its own timing from that edge.
- R10: After the last word of a finite burst, rd_ready stays low until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration value to write |
| sig_addr | input | 8 | Register read address |
| sig_data | output | 16 | Register read data |
| rd_strobe | input | 1 | Address strobe that starts a burst |
| rd_addr | input | ADDR_W | Read address (burst start, or asynchronous address) |
| rd_data | output | 16 | Read data |
| rd_ready | output | 1 | High when rd_data is (or, with lead timing, will be) valid |

## Verification
A wrong state or counter in the sequencer shows up at the first sampled cycle where rd_ready differs from the computed validity window. With lead timing this can happen one cycle before the data is affected. A wrong index or window calculation shows up as a mismatched rd_data word in the first cycle of the affected word. A corrupted configuration register is visible at once through register 05h, and within one burst through latency or order errors.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int CFG_W     = 16;
    localparam int WORD_W    = 16;
    localparam int REG_AW    = 8;
    localparam int LAT_W     = 5;
    localparam int YLAT_W    = 3;
    localparam int BLEN_W    = 4;

    // bit positions whose behaviour depends on them
    localparam int B_MODE    = 15;
    localparam int B_XHI     = 13;
    localparam int B_XLO     = 11;
    localparam int B_DIV     = 10;
    localparam int B_YSEL    = 9;
    localparam int B_LEAD    = 8;
    localparam int B_ORDER   = 7;

    localparam logic [CFG_W-1:0]  CFG_RESET = 16'h8000;
    localparam logic [CFG_W-1:0]  CFG_WMASK = 16'hBFC7;
    localparam logic [REG_AW-1:0] CFG_RADDR = 8'h05;

    localparam logic [2:0] LEN_CODE_8    = 3'b010;
    localparam logic [2:0] LEN_CODE_CONT = 3'b111;

    typedef enum logic [1:0] {
        ST_ASYNC = 2'd0,
        ST_IDLE  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DATA  = 2'd3
    } bsr_state_e;

    typedef struct packed {
        logic              async_mode;
        logic              ready_lead;
        logic              seq_order;
        logic              cont;
        logic [BLEN_W-1:0] blen;
        logic [LAT_W-1:0]  xlat;
        logic [YLAT_W-1:0] ylat;
    } bsr_mode_t;

endpackage

// File: rtl/bsr_cfg_reg.sv
module bsr_cfg_reg
    import bsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_W-1:0]  wdata,
    input  logic [REG_AW-1:0] raddr,
    output logic [CFG_W-1:0]  rdata,
    output logic [CFG_W-1:0]  cfg_word,
    output bsr_mode_t         mode
);

    // one flop per writable bit, constant zero for reserved bits
    for (genvar i = 0; i < CFG_W; i++) begin : g_bit
        if (CFG_WMASK[i]) begin : g_flop
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  bit_q <= CFG_RESET[i];
                else if (we) bit_q <= wdata[i];
            end
            assign cfg_word[i] = bit_q;
        end else begin : g_zero
            assign cfg_word[i] = 1'b0;
        end
    end

    assign rdata = (raddr == CFG_RADDR) ? cfg_word : '0;

    logic [LAT_W-1:0]  x_base;
    logic [YLAT_W-1:0] y_base;

    always_comb begin
        x_base = LAT_W'(cfg_word[B_XHI:B_XLO]) + LAT_W'(2);
        y_base = cfg_word[B_YSEL] ? YLAT_W'(2) : YLAT_W'(1);

        mode.async_mode = cfg_word[B_MODE];
        mode.ready_lead = cfg_word[B_LEAD];
        mode.seq_order  = cfg_word[B_ORDER];
        mode.cont       = (cfg_word[2:0] == LEN_CODE_CONT);
        mode.blen       = (cfg_word[2:0] == LEN_CODE_8) ? BLEN_W'(8) : BLEN_W'(4);
        mode.xlat       = cfg_word[B_DIV] ? (x_base << 1) : x_base;
        mode.ylat       = cfg_word[B_DIV] ? (y_base << 1) : y_base;
    end

endmodule

// File: rtl/bsr_addr_gen.sv
module bsr_addr_gen
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] idx,
    input  logic              seq_order,
    input  logic              cont,
    input  logic [BLEN_W-1:0] blen,
    output logic [ADDR_W-1:0] word_addr
);

    localparam logic [ADDR_W-1:0] MASK4 = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] MASK8 = ADDR_W'(7);

    logic [ADDR_W-1:0] win_mask;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] off;

    always_comb begin
        win_mask = (blen == BLEN_W'(8)) ? MASK8 : MASK4;
        base     = start_addr & ~win_mask;
        off      = start_addr & win_mask;
        if (cont)
            word_addr = start_addr + idx;
        else if (seq_order)
            word_addr = base | ((off + idx) & win_mask);
        else
            word_addr = base | ((off ^ idx) & win_mask);
    end

endmodule

// File: rtl/bsr_word_rom.sv
module bsr_word_rom
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] data
);

    localparam logic [15:0] MULT = 16'h2F1B;
    localparam logic [15:0] SALT = 16'hC3A5;

    logic [15:0] a16;

    always_comb begin
        a16  = 16'(addr);
        data = WORD_W'((a16 * MULT) ^ SALT);
    end

endmodule

// File: rtl/bsr_burst_reader.sv
module bsr_burst_reader
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    input  logic [7:0]        sig_addr,
    output logic [15:0]       sig_data,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    output logic              rd_ready
);

    logic [CFG_W-1:0]  cfg_word;
    bsr_mode_t         mode;

    bsr_state_e        state_q, state_d;
    logic [LAT_W-1:0]  lat_cnt_q;
    logic [ADDR_W-1:0] idx_q;
    logic [ADDR_W-1:0] start_q;
    logic              bp_seq_q;
    logic              bp_cont_q;
    logic [BLEN_W-1:0] bp_blen_q;
    logic [YLAT_W-1:0] bp_ylat_q;
    logic [WORD_W-1:0] data_q;

    logic [ADDR_W-1:0] gen_idx;
    logic [ADDR_W-1:0] gen_addr;
    logic [WORD_W-1:0] burst_word;
    logic [WORD_W-1:0] async_word;
    logic              strobe_go;
    logic              lat_done;
    logic              last_word;
    logic              valid_now;
    logic              valid_next;

    bsr_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .raddr    (sig_addr),
        .rdata    (sig_data),
        .cfg_word (cfg_word),
        .mode     (mode)
    );

    bsr_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .start_addr (start_q),
        .idx        (gen_idx),
        .seq_order  (bp_seq_q),
        .cont       (bp_cont_q),
        .blen       (bp_blen_q),
        .word_addr  (gen_addr)
    );

    bsr_word_rom #(.ADDR_W(ADDR_W)) u_rom_burst (
        .addr (gen_addr),
        .data (burst_word)
    );

    bsr_word_rom #(.ADDR_W(ADDR_W)) u_rom_async (
        .addr (rd_addr),
        .data (async_word)
    );

    assign strobe_go = rd_strobe & ~mode.async_mode;
    assign lat_done  = (lat_cnt_q == '0);
    assign last_word = ~bp_cont_q && (idx_q == ADDR_W'(bp_blen_q - BLEN_W'(1)));
    assign gen_idx   = (state_q == ST_DATA) ? (idx_q + ADDR_W'(1)) : idx_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (mode.async_mode) begin
            state_d = ST_ASYNC;                       // mode-async
        end else if (rd_strobe) begin
            state_d = ST_WAIT;                        // strobe-latch
        end else begin
            unique case (state_q)
                ST_ASYNC: state_d = ST_IDLE;          // mode-sync
                ST_IDLE:  state_d = ST_IDLE;
                ST_WAIT:  if (lat_done) state_d = ST_DATA;   // latency-expire
                ST_DATA:  if (lat_done && last_word) state_d = ST_IDLE; // burst-end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ASYNC;
        else        state_q <= state_d;
    end

    // burst datapath: latency counter, word index, held word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cnt_q <= '0;
            idx_q     <= '0;
            start_q   <= '0;
            bp_seq_q  <= 1'b0;
            bp_cont_q <= 1'b0;
            bp_blen_q <= BLEN_W'(4);
            bp_ylat_q <= YLAT_W'(1);
            data_q    <= '0;
        end else if (strobe_go) begin
            start_q   <= rd_addr;
            idx_q     <= '0;
            lat_cnt_q <= mode.xlat - LAT_W'(1);
            bp_seq_q  <= mode.seq_order;
            bp_cont_q <= mode.cont;
            bp_blen_q <= mode.blen;
            bp_ylat_q <= mode.ylat;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    if (lat_done) begin
                        data_q    <= burst_word;
                        lat_cnt_q <= LAT_W'(bp_ylat_q) - LAT_W'(1);
                    end else begin
                        lat_cnt_q <= lat_cnt_q - LAT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (lat_done) begin
                        if (!last_word) begin          // word-advance
                            idx_q     <= idx_q + ADDR_W'(1);
                            data_q    <= burst_word;
                            lat_cnt_q <= LAT_W'(bp_ylat_q) - LAT_W'(1);
                        end
                    end else begin
                        lat_cnt_q <= lat_cnt_q - LAT_W'(1);
                    end
                end
                ST_ASYNC, ST_IDLE: begin
                    lat_cnt_q <= lat_cnt_q;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        valid_now  = (state_q == ST_DATA);
        valid_next = (state_d == ST_DATA);
        if (mode.async_mode) begin
            rd_data  = async_word;
            rd_ready = 1'b1;
        end else begin
            rd_data  = data_q;
            rd_ready = mode.ready_lead ? valid_next : valid_now;
        end
    end

endmodule

// File: rtl/bsr_burst_reader_chk.sv
module bsr_burst_reader_chk
    import bsr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             rd_strobe,
    input logic             rd_ready,
    input logic [15:0]      rd_data,
    input logic [CFG_W-1:0] cfg_word,
    input bsr_state_e       state_q,
    input logic [LAT_W-1:0] lat_cnt_q
);

    a_r2_async_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_word[B_MODE] |-> rd_ready);

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) || (state_q != ST_DATA) |-> (cfg_word[14] == 1'b0) && (cfg_word[5:3] == 3'b000));

    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_word[B_MODE] && rd_strobe && !cfg_we) |=> (state_q == ST_WAIT));

    a_r5_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_word[B_MODE] && !cfg_we && !rd_strobe && state_q == ST_DATA && lat_cnt_q != '0)
        |=> $stable(rd_data));

    a_r6_lead_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_word[B_MODE] && cfg_word[B_LEAD] && !cfg_we && rd_ready) |=> (state_q == ST_DATA));

    a_r4_wait_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_word[B_MODE] && !cfg_word[B_LEAD] && state_q == ST_WAIT) |-> !rd_ready);

    a_r10_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_word[B_MODE] && !cfg_word[B_LEAD] && state_q == ST_IDLE) |-> !rd_ready);

endmodule

bind bsr_burst_reader bsr_burst_reader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .rd_strobe (rd_strobe),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .cfg_word  (cfg_word),
    .state_q   (state_q),
    .lat_cnt_q (lat_cnt_q)
);

// File: tb/bsr_burst_reader_bench.sv
module bsr_burst_reader_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    // {config word, start address}
    localparam logic [23:0] VEC [NVEC] = '{
        {16'h0081, 8'h12},  // R7 sequential 4, X=2
        {16'h1802, 8'h35},  // R7 interleaved 8, X=5
        {16'h3481, 8'h07},  // R4 R5 divide: 16-2-2-2
        {16'h0B82, 8'hFE},  // R5 Y=2, R6 lead, sequential 8 wrap in window
        {16'h1101, 8'h43},  // R6 lead, interleaved 4
        {16'h0087, 8'hFD},  // R7 continuous across array end
        {16'h0803, 8'h21},  // R7 unlisted length code -> 4, interleaved
        {16'h2702, 8'h5C},  // R4 R5 R6 divide + Y=2 + lead, interleaved 8
        {16'h00C1, 8'h12}   // R8 edge bit set: same as first vector
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [7:0]  sig_addr = 8'h05;
    logic [15:0] sig_data;
    logic        rd_strobe = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        rd_ready;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsr_burst_reader #(.ADDR_W(8)) u_bsr_burst_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .sig_addr  (sig_addr),
        .sig_data  (sig_data),
        .rd_strobe (rd_strobe),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rd_ready  (rd_ready)
    );

    function automatic logic [15:0] exp_word(input logic [7:0] a);
        logic [15:0] t;
        t = {8'h00, a} * 16'h2F1B;
        return t ^ 16'hC3A5;
    endfunction

    function automatic logic [7:0] exp_addr(input logic [7:0] s, input int k,
                                            input int len, input bit cont, input bit seq);
        logic [7:0] m;
        logic [7:0] kk;
        kk = k[7:0];
        if (cont) return s + kk;
        m = (len == 8) ? 8'd7 : 8'd3;
        if (seq) return (s & ~m) | (((s & m) + kk) & m);
        return (s & ~m) | (((s & m) ^ kk) & m);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // strobe a burst and check n cycles (0 = whole burst plus tail)
    task automatic run_burst(input logic [15:0] cfg, input logic [7:0] a, input int n_in);
        int  xl, yl, len, n;
        bit  cont, seq, lead, v, vn;
        xl   = (int'(cfg[13:11]) + 2) * (cfg[10] ? 2 : 1);
        yl   = (cfg[9] ? 2 : 1) * (cfg[10] ? 2 : 1);
        len  = (cfg[2:0] == 3'b010) ? 8 : 4;
        cont = (cfg[2:0] == 3'b111);
        seq  = cfg[7];
        lead = cfg[8];
        n    = (n_in != 0) ? n_in : (cont ? xl + 24 : xl + len * yl + 3);
        @(negedge clk);
        rd_strobe = 1'b1;
        rd_addr   = a;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            v  = (c >= xl)     && (cont || c     < xl + len * yl);
            vn = (c + 1 >= xl) && (cont || c + 1 < xl + len * yl);
            if (c >= xl + len * yl && !cont)
                chk("R10 ready after burst end", {15'b0, rd_ready}, {15'b0, lead ? vn : v});
            else
                chk("R6 ready timing", {15'b0, rd_ready}, {15'b0, lead ? vn : v});
            if (v)
                chk("R4 R5 R7 burst word", rd_data,
                    exp_word(exp_addr(a, (c - xl) / yl, len, cont, seq)));
            if (c == 0) rd_strobe = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset config", sig_data, 16'h8000);
        chk("R1 reset async ready", {15'b0, rd_ready}, 16'h0001);

        // asynchronous reads
        rd_addr = 8'h3C;
        #1;
        chk("R2 async word", rd_data, exp_word(8'h3C));
        @(negedge clk);
        rd_strobe = 1'b1;
        rd_addr   = 8'h91;
        @(negedge clk);
        chk("R2 strobe ignored ready", {15'b0, rd_ready}, 16'h0001);
        chk("R2 strobe ignored data", rd_data, exp_word(8'h91));
        rd_strobe = 1'b0;

        // register read path
        sig_addr = 8'h04;
        #1;
        chk("R3 other address", sig_data, 16'h0000);
        sig_addr = 8'h05;
        cfg_we    = 1'b1;
        cfg_wdata = 16'h0081;
        #1;
        chk("R3 write not yet visible", sig_data, 16'h8000);
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R3 write visible", sig_data, 16'h0081);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            write_cfg(VEC[i][23:8]);
            chk("R3 readback", sig_data, VEC[i][23:8] & 16'hBFC7);
            run_burst(VEC[i][23:8], VEC[i][7:0], 0);
        end

        // R9 abort then restart
        write_cfg(16'h1881);
        run_burst(16'h1881, 8'h10, 7);
        run_burst(16'h1881, 8'h80, 0);

        // R10 idle stays low
        repeat (4) begin
            @(negedge clk);
            chk("R10 idle ready low", {15'b0, rd_ready}, 16'h0000);
        end

        // R8 reserved bits
        write_cfg(16'hFFFF);
        chk("R8 reserved read zero", sig_data, 16'hBFC7);
        chk("R2 async after write", {15'b0, rd_ready}, 16'h0001);

        // back to async with plain word
        write_cfg(16'h8000);
        rd_addr = 8'hA7;
        #1;
        chk("R2 async word again", rd_data, exp_word(8'hA7));

        // R1 reset restores the default
        write_cfg(16'h0081);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset restores config", sig_data, 16'h8000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule